// File: doc/BRIEF.md
# Software-Select Conversion Sequencer for a Six-Channel Parallel ADC

This block is the host-side controller for a six-channel simultaneous-sampling converter that is driven over a 16-bit parallel bus in software-select mode. When a start request is accepted, the block latches three pair-enable bits, three range bits and two reference options. It writes them as an 8-bit control word on the upper half of the bus with a chip-select/write cycle. It then pulses the single convert line and waits for the converter's busy flag to rise and fall. After that it issues exactly as many read strobes as the chosen pairs and transfer width need.

Each captured result is presented for one cycle with a channel tag, in ascending channel order. In word mode every read returns one full 16-bit result. In byte mode every result takes two reads on the low byte lane, high byte first. A request that enables no pair produces an error pulse and causes no bus activity. All strobe widths and gaps are parameters counted in clocks.

Top module: `adc_swseq`

## Requirements
- R1: While the control word is driven, bus_o[15:8] carries, from bit 15 down, pair_sel_i[2] (channels 5-6), pair_sel_i[1] (channels 3-4), pair_sel_i[0] (channels 1-2), range_i[2], range_i[1], range_i[0], ref_int_i, ref_buf_off_i, and bus_o[7:0] is zero.
- R2: The write cycle holds cs_n_o and wr_n_o low with rd_n_o high and bus_oe_o high. The data and cs_n_o stay driven through the rising edge of wr_n_o, and there is exactly one write cycle per accepted request.
- R3: Each accepted request gives exactly one high pulse on cnv_a_o, issued after the write cycle. cnv_b_o and cnv_c_o never leave low.
- R4: No read strobe falls before busy_i has been seen high and then low after the convert pulse.
- R5: In word mode there is one read strobe per enabled channel (two per enabled pair), and res_data_o equals the full 16-bit bus_i value sampled at the end of that strobe.
- R6: In byte mode there are two read strobes per enabled channel (four per pair). The first returns the high byte and the second the low byte, both on bus_i[7:0], and bus_i[15:8] is ignored.
- R7: Results appear on res_valid_o one per enabled channel, in ascending channel order. res_chan_o holds the channel number 1 to 6.
- R8: bus_oe_o is low whenever rd_n_o is low, and cs_n_o is low during every read strobe.
- R9: Every write strobe and read strobe stays low for at least STROBE_CLKS clocks. Consecutive read strobes are separated by at least GAP_CLKS high clocks.
- R10: A start request with pair_sel_i equal to zero gives a one-cycle err_o pulse and no write, convert or read activity.
- R11: During and right after reset, cs_n_o, wr_n_o and rd_n_o are high, cnv_a_o, bus_oe_o, res_valid_o, err_o and done_o are low.
- R12: start_i is ignored while a sequence runs. done_o pulses once after the last result of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| pair_sel_i | input | 3 | Pair enables, bit 0 = channels 1-2 |
| range_i | input | 3 | Range per pair, 1 = 2xVREF, 0 = 4xVREF |
| ref_int_i | input | 1 | 1 = internal reference |
| ref_buf_off_i | input | 1 | 1 = internal reference buffers off |
| byte_mode_i | input | 1 | 1 = byte transfers, 0 = word transfers |
| busy_i | input | 1 | Converter busy flag |
| bus_i | input | 16 | Data read from the converter bus |
| bus_o | output | 16 | Data driven onto the converter bus |
| bus_oe_o | output | 1 | Bus drive enable, low = high impedance |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| cnv_a_o | output | 1 | Convert start for the selected pairs |
| cnv_b_o | output | 1 | Second convert line, held low |
| cnv_c_o | output | 1 | Third convert line, held low |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | 16 | Assembled result |
| res_chan_o | output | 3 | Channel number of the result, 1 to 6 |
| err_o | output | 1 | Pulse: request had no pair enabled |
| done_o | output | 1 | Pulse: sequence finished |

## Verification
A wrong channel walker or a wrong enable decode shows up on the ports within a single sequence. The read-strobe count is off, a result carries the wrong tag or falls out of ascending order, or the data belongs to a neighbouring channel, because the bench's converter model returns a channel-unique value. A corrupted control word changes which channels the model returns, so the results of the same conversion disagree with the request. A faulty timer or state decode shows up first as a strobe shorter than its minimum, a read while busy, or the bus still driven during a read. Such a fault is visible on the first strobe it affects.

// File: rtl/adc_swseq_pkg.sv
// Package: shared widths, sequencer state type and channel helpers.
// Assumes channels are numbered 1..2*NPAIR and pair p holds channels 2p+1, 2p+2.
package adc_swseq_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NPAIR  = 3;
    localparam int CTL_W  = 2 * NPAIR + 2;
    localparam int CH_W   = $clog2(2 * NPAIR + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HOLD,
        S_CNV,
        S_BUSY_HI,
        S_BUSY_LO,
        S_RD_LO,
        S_RD_GAP,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [NPAIR-1:0] sel;
        logic [NPAIR-1:0] rng;
        logic             ref_int;
        logic             buf_off;
        logic             byte_mode;
    } seq_cfg_t;

    // Control word: pair enables (highest pair first), ranges, reference options.
    function automatic logic [CTL_W-1:0] ctl_word(seq_cfg_t c);
        return {c.sel, c.rng, c.ref_int, c.buf_off};
    endfunction

    // Smallest enabled channel number above cur, or 0 when none is left.
    function automatic logic [CH_W-1:0] next_chan(logic [CH_W-1:0] cur,
                                                  logic [NPAIR-1:0] sel);
        logic [CH_W-1:0] r;
        r = '0;
        for (int c = 2 * NPAIR; c >= 1; c--) begin
            if (c > int'(cur) && sel[(c - 1) / 2]) r = CH_W'(c);
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_swseq_timer.sv
// Module: down-counting interval timer.
// A load sets the count, which then falls by one each clock to zero.
// zero_o is high when the count is zero, so a state loaded with N-1
// lasts N clocks. Assumes load values fit in CNT_W bits.
module adc_swseq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_swseq_walker.sv
// Module: channel walker.
// Tracks the channel being read and, in byte mode, which half is next.
// init_i loads the lowest enabled channel from init_sel_i. step_i advances
// after each read. last_o flags that the current read is the final one.
// Assumes sel_i is stable between init_i and the last step.
module adc_swseq_walker
    import adc_swseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [NPAIR-1:0] init_sel_i,
    input  logic [NPAIR-1:0] sel_i,
    input  logic             byte_mode_i,
    input  logic             step_i,
    output logic [CH_W-1:0]  chan_o,
    output logic             half_o,
    output logic             last_o
);

    logic [CH_W-1:0] chan_q;
    logic            half_q;
    logic [CH_W-1:0] chan_nxt;

    assign chan_nxt = next_chan(chan_q, sel_i);

    // Position register: start at the first channel, then walk upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            half_q <= 1'b0;
        end else if (init_i) begin
            chan_q <= next_chan('0, init_sel_i);
            half_q <= 1'b0;
        end else if (step_i) begin
            if (byte_mode_i && !half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                chan_q <= chan_nxt;
            end
        end
    end

    // Final read: no higher channel, and the second half done in byte mode.
    always_comb begin
        last_o = (chan_nxt == '0) && (!byte_mode_i || half_q);
    end

    assign chan_o = chan_q;
    assign half_o = half_q;

endmodule

// File: rtl/adc_swseq_assemble.sv
// Module: result assembler.
// In word mode each capture becomes a result. In byte mode the first
// capture of a channel keeps the high byte and the second one completes the
// result from the low byte lane. Outputs are registered, one cycle after
// the capture.
module adc_swseq_assemble
    import adc_swseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             byte_mode_i,
    input  logic             half_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             valid_o,
    output logic [BUS_W-1:0] data_o,
    output logic [CH_W-1:0]  chan_o
);

    localparam int HI_W = BUS_W - BYTE_W;

    logic [HI_W-1:0] hi_q;
    logic            valid_q;
    logic [BUS_W-1:0] data_q;
    logic [CH_W-1:0]  chan_q;

    // Capture path: keep the high byte or emit a full result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
            chan_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (capture_i) begin
                if (byte_mode_i && !half_i) begin
                    hi_q <= HI_W'(bus_i[BYTE_W-1:0]);
                end else begin
                    valid_q <= 1'b1;
                    chan_q  <= chan_i;
                    data_q  <= byte_mode_i ? {hi_q, bus_i[BYTE_W-1:0]} : bus_i;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign chan_o  = chan_q;

endmodule

// File: rtl/adc_swseq.sv
// Module: software-select conversion sequencer (top).
// Per accepted request it writes the control word, pulses the convert
// line, waits for busy to rise and fall, then reads every enabled channel
// in ascending order. Assumes the converter drives read data while cs_n/rd_n
// are low and that the data is stable by the end of the strobe.
module adc_swseq
    import adc_swseq_pkg::*;
#(
    parameter int STROBE_CLKS = 3,
    parameter int GAP_CLKS    = 2,
    parameter int CNV_CLKS    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NPAIR-1:0] pair_sel_i,
    input  logic [NPAIR-1:0] range_i,
    input  logic             ref_int_i,
    input  logic             ref_buf_off_i,
    input  logic             byte_mode_i,
    input  logic             busy_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] bus_o,
    output logic             bus_oe_o,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             cnv_a_o,
    output logic             cnv_b_o,
    output logic             cnv_c_o,
    output logic             res_valid_o,
    output logic [BUS_W-1:0] res_data_o,
    output logic [CH_W-1:0]  res_chan_o,
    output logic             err_o,
    output logic             done_o
);

    localparam int TMAX  = (STROBE_CLKS > GAP_CLKS)
                         ? ((STROBE_CLKS > CNV_CLKS) ? STROBE_CLKS : CNV_CLKS)
                         : ((GAP_CLKS > CNV_CLKS) ? GAP_CLKS : CNV_CLKS);
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_STROBE = TW'(STROBE_CLKS - 1);
    localparam logic [TW-1:0] T_GAP    = TW'(GAP_CLKS - 1);
    localparam logic [TW-1:0] T_CNV    = TW'(CNV_CLKS - 1);

    seq_state_t state_q, state_nxt;
    seq_cfg_t   cfg_q;
    logic       err_q;
    logic       last_q;

    logic          accept;
    logic          reject;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          capture;
    logic [CH_W-1:0] walk_chan;
    logic          walk_half;
    logic          walk_last;

    assign accept  = (state_q == S_IDLE) && start_i && (pair_sel_i != '0);
    assign reject  = (state_q == S_IDLE) && start_i && (pair_sel_i == '0);
    assign capture = (state_q == S_RD_LO) && tmr_zero;

    // Next-state and timer-load decode.
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_nxt = S_WR_LO;
                    tmr_load  = 1'b1;
                    tmr_val   = T_STROBE;
                end
            end
            S_WR_LO: begin
                if (tmr_zero) begin
                    state_nxt = S_WR_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = T_GAP;
                end
            end
            S_WR_HOLD: begin
                if (tmr_zero) begin
                    state_nxt = S_CNV;
                    tmr_load  = 1'b1;
                    tmr_val   = T_CNV;
                end
            end
            S_CNV: begin
                if (tmr_zero) state_nxt = S_BUSY_HI;
            end
            S_BUSY_HI: begin
                if (busy_i) state_nxt = S_BUSY_LO;
            end
            S_BUSY_LO: begin
                if (!busy_i) begin
                    state_nxt = S_RD_LO;
                    tmr_load  = 1'b1;
                    tmr_val   = T_STROBE;
                end
            end
            S_RD_LO: begin
                if (tmr_zero) begin
                    state_nxt = S_RD_GAP;
                    tmr_load  = 1'b1;
                    tmr_val   = T_GAP;
                end
            end
            S_RD_GAP: begin
                if (tmr_zero) begin
                    if (last_q) begin
                        state_nxt = S_DONE;
                    end else begin
                        state_nxt = S_RD_LO;
                        tmr_load  = 1'b1;
                        tmr_val   = T_STROBE;
                    end
                end
            end
            S_DONE: state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // State, latched configuration, error pulse and last-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            err_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            err_q   <= reject;
            if (accept) begin
                cfg_q.sel       <= pair_sel_i;
                cfg_q.rng       <= range_i;
                cfg_q.ref_int   <= ref_int_i;
                cfg_q.buf_off   <= ref_buf_off_i;
                cfg_q.byte_mode <= byte_mode_i;
                last_q          <= 1'b0;
            end else if (capture) begin
                last_q <= walk_last;
            end
        end
    end

    // Bus pin decode from the current state.
    always_comb begin
        cs_n_o   = !((state_q == S_WR_LO) || (state_q == S_WR_HOLD) ||
                     (state_q == S_RD_LO));
        wr_n_o   = (state_q != S_WR_LO);
        rd_n_o   = (state_q != S_RD_LO);
        bus_oe_o = (state_q == S_WR_LO) || (state_q == S_WR_HOLD);
        bus_o    = bus_oe_o ? {ctl_word(cfg_q), {(BUS_W - CTL_W){1'b0}}} : '0;
        cnv_a_o  = (state_q == S_CNV);
        done_o   = (state_q == S_DONE);
    end

    assign cnv_b_o = 1'b0;
    assign cnv_c_o = 1'b0;
    assign err_o   = err_q;

    adc_swseq_timer #(
        .CNT_W (TW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc_swseq_walker u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (accept),
        .init_sel_i  (pair_sel_i),
        .sel_i       (cfg_q.sel),
        .byte_mode_i (cfg_q.byte_mode),
        .step_i      (capture),
        .chan_o      (walk_chan),
        .half_o      (walk_half),
        .last_o      (walk_last)
    );

    adc_swseq_assemble u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture),
        .byte_mode_i (cfg_q.byte_mode),
        .half_i      (walk_half),
        .chan_i      (walk_chan),
        .bus_i       (bus_i),
        .valid_o     (res_valid_o),
        .data_o      (res_data_o),
        .chan_o      (res_chan_o)
    );

endmodule

// File: rtl/adc_swseq_chk.sv
// Module: protocol checker for adc_swseq, attached by bind.
// Watches only the top-level pins. Strobe width is measured with a
// saturating counter.
module adc_swseq_chk #(
    parameter int STROBE_CLKS = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_o,
    input logic       wr_n_o,
    input logic       rd_n_o,
    input logic       bus_oe_o,
    input logic       cnv_a_o,
    input logic       busy_i,
    input logic       res_valid_o,
    input logic [2:0] res_chan_o,
    input logic       err_o
);

    int lo_cnt;

    // Count consecutive low clocks of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_cnt <= 0;
        else if (!rd_n_o) lo_cnt <= (lo_cnt < 1000) ? lo_cnt + 1 : lo_cnt;
        else lo_cnt <= 0;
    end

    // R2
    wr_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (!cs_n_o && rd_n_o && bus_oe_o));

    // R2
    wr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> (!cs_n_o && bus_oe_o));

    // R8
    rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!bus_oe_o && !cs_n_o));

    // R4
    rd_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> !busy_i);

    // R9
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> (lo_cnt >= STROBE_CLKS));

    // R7
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_chan_o >= 3'd1 && res_chan_o <= 3'd6));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cs_n_o && !cnv_a_o));

    // R3
    cnv_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_a_o |-> (cs_n_o && wr_n_o && rd_n_o && !bus_oe_o));

endmodule

bind adc_swseq adc_swseq_chk #(
    .STROBE_CLKS (STROBE_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .wr_n_o      (wr_n_o),
    .rd_n_o      (rd_n_o),
    .bus_oe_o    (bus_oe_o),
    .cnv_a_o     (cnv_a_o),
    .busy_i      (busy_i),
    .res_valid_o (res_valid_o),
    .res_chan_o  (res_chan_o),
    .err_o       (err_o)
);

// File: tb/tb_adc_swseq.sv
// Bench: converter model plus a table walk and directed tests for adc_swseq.
module tb_adc_swseq;

    localparam int STROBE = 3;
    localparam int GAP    = 2;
    localparam int CNV    = 2;
    localparam int NVEC   = 8;
    // {sel[2:0], range[2:0], ref_int, buf_off, byte_mode}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b001_000_00_0, 9'b111_101_10_0, 9'b010_010_01_1, 9'b100_111_11_1,
        9'b101_001_00_0, 9'b111_000_01_1, 9'b011_110_10_1, 9'b110_011_11_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  pair_sel_i = '0;
    logic [2:0]  range_i = '0;
    logic        ref_int_i = 1'b0;
    logic        ref_buf_off_i = 1'b0;
    logic        byte_mode_i = 1'b0;
    logic        busy_i = 1'b0;
    logic [15:0] bus_i = '0;
    logic [15:0] bus_o;
    logic        bus_oe_o, cs_n_o, wr_n_o, rd_n_o, cnv_a_o, cnv_b_o, cnv_c_o;
    logic        res_valid_o, err_o, done_o;
    logic [15:0] res_data_o;
    logic [2:0]  res_chan_o;

    adc_swseq #(.STROBE_CLKS(STROBE), .GAP_CLKS(GAP), .CNV_CLKS(CNV)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_sel_i(pair_sel_i),
        .range_i(range_i), .ref_int_i(ref_int_i), .ref_buf_off_i(ref_buf_off_i),
        .byte_mode_i(byte_mode_i), .busy_i(busy_i), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe_o(bus_oe_o), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o),
        .cnv_a_o(cnv_a_o), .cnv_b_o(cnv_b_o), .cnv_c_o(cnv_c_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_chan_o(res_chan_o),
        .err_o(err_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_val(int ch, int conv);
        return {4'(ch), 4'(conv), 8'(8'h3C ^ 8'(ch * 17))};
    endfunction

    // Converter model and pin monitors, all sampled on the falling edge.
    logic        prev_wr = 1'b1, prev_rd = 1'b1, prev_cnv = 1'b0;
    logic [7:0]  ctl_seen = '0;
    logic [15:0] rd_vals [12];
    int wr_cnt = 0, rd_cnt = 0, cnv_cnt = 0, conv_no = 0, bcnt = 0, rd_idx = 0;
    int lo_run = 0, hi_run = 0, wr_run = 0, min_lo = 999, min_gap = 999, min_wr = 999;
    int bus_viol = 0, bc_viol = 0, early_rd = 0, low_byte_bad = 0, cnv_len_bad = 0, cnv_run = 0;
    bit have_prev = 0, seen_busy = 0;

    always @(negedge clk) begin
        if (cnv_b_o || cnv_c_o) bc_viol++;
        if (!rd_n_o && (bus_oe_o || cs_n_o)) bus_viol++;
        if (prev_wr && !wr_n_o) begin wr_cnt++; wr_run = 0; end
        if (!prev_wr && wr_n_o) begin
            if (wr_run < min_wr) min_wr = wr_run;
            if (!cs_n_o && bus_oe_o) ctl_seen = bus_o[15:8];
            if (bus_o[7:0] != 8'h00) low_byte_bad++;
        end
        if (!wr_n_o) wr_run++;
        if (!prev_cnv && cnv_a_o) begin
            int n;
            cnv_cnt++;
            cnv_run = 0;
            busy_i = 1'b1;
            seen_busy = 1'b0;
            bcnt = 6;
            n = 0;
            for (int ch = 1; ch <= 6; ch++) begin
                if (ctl_seen[5 + (ch - 1) / 2]) begin
                    logic [15:0] v;
                    v = model_val(ch, conv_no);
                    if (byte_mode_i) begin
                        rd_vals[n] = {8'hEE, v[15:8]}; n++;
                        rd_vals[n] = {8'h77, v[7:0]};  n++;
                    end else begin
                        rd_vals[n] = v; n++;
                    end
                end
            end
            conv_no++;
            rd_idx = 0;
            have_prev = 0;
        end else if (busy_i) begin
            seen_busy = 1'b1;
            bcnt--;
            if (bcnt == 0) busy_i = 1'b0;
        end
        if (prev_cnv && !cnv_a_o && cnv_run != CNV) cnv_len_bad++;
        if (cnv_a_o) cnv_run++;
        if (prev_rd && !rd_n_o) begin
            rd_cnt++;
            if (busy_i || !seen_busy) early_rd++;
            if (have_prev && hi_run < min_gap) min_gap = hi_run;
            lo_run = 0;
            bus_i = (rd_idx < 12) ? rd_vals[rd_idx] : 16'hDEAD;
            rd_idx++;
        end
        if (!prev_rd && rd_n_o) begin
            if (lo_run < min_lo) min_lo = lo_run;
            hi_run = 0;
            have_prev = 1;
        end
        if (!rd_n_o) lo_run++; else hi_run++;
        prev_wr = wr_n_o;
        prev_rd = rd_n_o;
        prev_cnv = cnv_a_o;
    end

    // Result collector.
    logic [15:0] res_d [64];
    logic [2:0]  res_c [64];
    int n_res = 0;
    always @(negedge clk) begin
        if (res_valid_o) begin
            if (n_res < 64) begin
                res_d[n_res] = res_data_o;
                res_c[n_res] = res_chan_o;
            end
            n_res++;
        end
    end

    int exp_conv = 0;

    // Run one accepted request and check every output it produces.
    task automatic run_case(logic [8:0] v, bit mid_start);
        int base, rd0, nch, k, waited;
        bit got_done;
        @(negedge clk);
        pair_sel_i = v[8:6]; range_i = v[5:3];
        ref_int_i = v[2]; ref_buf_off_i = v[1]; byte_mode_i = v[0];
        base = n_res; rd0 = rd_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            @(negedge clk);
            @(negedge clk);
            pair_sel_i = ~v[8:6]; byte_mode_i = ~v[0]; range_i = ~v[5:3];
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            pair_sel_i = v[8:6]; range_i = v[5:3]; byte_mode_i = v[0];
        end
        got_done = 0;
        waited = 0;
        while (!got_done && waited < 3000) begin
            @(negedge clk);
            waited++;
            if (done_o) got_done = 1;
        end
        chk(got_done, "R12", "done pulse seen", int'(got_done), 1);
        // R1: control word layout
        chk(ctl_seen == {v[8:6], v[5:3], v[2], v[1]}, "R1", "control word",
            int'(ctl_seen), int'({v[8:6], v[5:3], v[2], v[1]}));
        nch = 2 * $countones(v[8:6]);
        // R5 / R6: number of read strobes
        chk(rd_cnt - rd0 == nch * (v[0] ? 2 : 1), v[0] ? "R6" : "R5", "read strobes",
            rd_cnt - rd0, nch * (v[0] ? 2 : 1));
        chk(n_res - base == nch, "R7", "result count", n_res - base, nch);
        k = base;
        for (int ch = 1; ch <= 6; ch++) begin
            if (v[6 + (ch - 1) / 2] && k < n_res && k < 64) begin
                chk(res_c[k] == 3'(ch), "R7", "channel tag order", int'(res_c[k]), ch);
                chk(res_d[k] == model_val(ch, exp_conv), v[0] ? "R6" : "R5", "result data",
                    int'(res_d[k]), int'(model_val(ch, exp_conv)));
                k++;
            end
        end
        exp_conv++;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wr0, cnv0, res0;
        repeat (3) @(negedge clk);
        // R11: outputs held quiet in reset
        chk(cs_n_o && wr_n_o && rd_n_o, "R11", "strobes high in reset",
            int'({cs_n_o, wr_n_o, rd_n_o}), 7);
        chk(!cnv_a_o && !bus_oe_o && !res_valid_o && !err_o && !done_o, "R11",
            "outputs low in reset",
            int'({cnv_a_o, bus_oe_o, res_valid_o, err_o, done_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o && wr_n_o && rd_n_o && !bus_oe_o && !cnv_a_o, "R11", "idle after reset",
            int'({cs_n_o, wr_n_o, rd_n_o, bus_oe_o, cnv_a_o}), 5'b11100);

        for (int i = 0; i < NVEC; i++) run_case(VEC[i], 1'b0);

        // R10: request with no pair enabled
        wr0 = wr_cnt; cnv0 = cnv_cnt; res0 = n_res;
        @(negedge clk);
        pair_sel_i = 3'b000; range_i = 3'b111; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o, "R10", "error pulse", int'(err_o), 1);
        @(negedge clk);
        chk(!err_o, "R10", "error pulse one cycle", int'(err_o), 0);
        repeat (30) @(negedge clk);
        chk(wr_cnt == wr0 && cnv_cnt == cnv0 && n_res == res0, "R10", "no bus activity",
            (wr_cnt - wr0) + (cnv_cnt - cnv0) + (n_res - res0), 0);

        // R12: start during a running sequence is ignored
        cnv0 = cnv_cnt; wr0 = wr_cnt;
        run_case(9'b010_001_10_0, 1'b1);
        repeat (60) @(negedge clk);
        chk(cnv_cnt == cnv0 + 1 && wr_cnt == wr0 + 1, "R12", "single sequence per request",
            cnv_cnt - cnv0, 1);

        // Protocol summaries gathered by the monitors
        chk(bus_viol == 0, "R8", "bus released during reads", bus_viol, 0);
        chk(early_rd == 0, "R4", "reads only after busy falls", early_rd, 0);
        chk(min_lo >= STROBE, "R9", "read strobe width", min_lo, STROBE);
        chk(min_gap >= GAP, "R9", "gap between reads", min_gap, GAP);
        chk(min_wr >= STROBE, "R9", "write strobe width", min_wr, STROBE);
        chk(bc_viol == 0, "R3", "second and third convert low", bc_viol, 0);
        chk(cnv_cnt == NVEC + 1, "R3", "convert pulses", cnv_cnt, NVEC + 1);
        chk(cnv_len_bad == 0, "R3", "convert pulse length", cnv_len_bad, 0);
        chk(wr_cnt == NVEC + 1, "R2", "write cycles", wr_cnt, NVEC + 1);
        chk(low_byte_bad == 0, "R1", "low bus byte zero on write", low_byte_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule